// File: doc/BRIEF.md
# Copy Channel Interrupt Aggregator

This block gathers the interrupt causes of a group of copy channels into per-channel status registers, one summary vector and one combined interrupt line. Each channel can raise four kinds of cause. A copy-complete pulse is one. An error pulse is another. The last two come from occupancy watermarks on the channel's source ring and on its destination ring; each ring has a high mark and a low mark. Every cause latches into its own status bit, and software clears a status bit by writing a one to it.

The enables decide which latched causes reach the summary vector. Copy-complete and the four watermark causes have their enable bits in a host enable register. The error cause has its enable in a separate miscellaneous enable register. The summary vector holds one bit per channel, and software scans it to find the channels that need service. The combined line is the registered OR of that vector. Software reaches every register through a simple address/data bus. The address carries the channel index above a 3-bit register select.

Top module: `cpy_irq_agg`

## Requirements
- R1: After reset all enables, status bits, summary bits and the combined line are 0. On each ring the low mark resets to 0 and the high mark resets to RING_DEPTH.
- R2: A copy-complete pulse sets status bit 0 and an error pulse sets status bit 5. The bit is set at the clock edge that samples the pulse.
- R3: On the source ring, status bit 1 is set when the occupancy goes from at or below the high mark to above it. On the destination ring the same crossing sets bit 3. Each crossing sets the bit once, however long the occupancy stays above the mark.
- R4: On the source ring, status bit 2 is set when the occupancy goes from at or above the low mark to below it. On the destination ring the same crossing sets bit 4. Each crossing sets the bit once.
- R5: A status bit latches whether or not its enable is set.
- R6: A write to the status register (select 2) clears every status bit whose data bit is 1 and leaves every other status bit unchanged.
- R7: When a new event and a clear of the same status bit fall in one cycle, the bit stays set.
- R8: A channel's summary bit is 1 when at least one of its status bits is set and enabled. Host enable (select 0) bits 0 to 4 enable status bits 0 to 4. Miscellaneous enable (select 1) bit 0 enables status bit 5.
- R9: The combined line equals the OR of the summary vector one clock cycle earlier.
- R10: Address = {channel, select}. Select 3 holds the source ring marks and select 4 the destination ring marks, each as low mark in data [OCC_W-1:0] and high mark in [2*OCC_W-1:OCC_W]. Select 5 reads the summary vector from any channel, and writes to select 5 change nothing. Every register reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Channel index above a 3-bit register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| done_pulse | input | NUM_CH | Copy-complete pulse per channel |
| err_pulse | input | NUM_CH | Error pulse per channel |
| src_occ | input | NUM_CH*OCC_W | Source ring occupancy per channel |
| dst_occ | input | NUM_CH*OCC_W | Destination ring occupancy per channel |
| chan_status | output | NUM_CH*STAT_W | Status register of every channel |
| ch_summary | output | NUM_CH | Pending-and-enabled summary vector |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The event that latches a cause and the write-one-to-clear of that same status bit can fall in the same cycle. The directed part provokes this on purpose: it drives a copy-complete pulse together with a status write that clears bit 0, and then reads the bit back. The random part produces the same overlap on many bits, from pulses, watermark crossings and clear writes that are drawn independently of each other. Each status, summary and combined-line value is compared with a bench model in which a new event wins over a clear.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    localparam int STAT_W = 6;
    localparam int HEN_W  = 5;

    localparam int B_DONE   = 0;
    localparam int B_SRC_HI = 1;
    localparam int B_SRC_LO = 2;
    localparam int B_DST_HI = 3;
    localparam int B_DST_LO = 4;
    localparam int B_ERR    = 5;

    typedef enum logic [2:0] {
        REG_HOST_EN = 3'd0,
        REG_MISC_EN = 3'd1,
        REG_STATUS  = 3'd2,
        REG_SRC_WM  = 3'd3,
        REG_DST_WM  = 3'd4,
        REG_SUMMARY = 3'd5,
        REG_NONE    = 3'd7
    } reg_sel_e;

    // Packed cause vector: first member is the MSB (status bit 5).
    typedef struct packed {
        logic err;
        logic dst_lo;
        logic dst_hi;
        logic src_lo;
        logic src_hi;
        logic done;
    } cause_t;

    function automatic reg_sel_e sel_decode(input logic [2:0] raw);
        case (raw)
            3'd0:    return REG_HOST_EN;
            3'd1:    return REG_MISC_EN;
            3'd2:    return REG_STATUS;
            3'd3:    return REG_SRC_WM;
            3'd4:    return REG_DST_WM;
            3'd5:    return REG_SUMMARY;
            default: return REG_NONE;
        endcase
    endfunction

    // Clear first, then set: a fresh event always survives its own clear.
    function automatic logic [STAT_W-1:0] w1c_merge(input logic [STAT_W-1:0] cur,
                                                    input logic [STAT_W-1:0] clr,
                                                    input logic [STAT_W-1:0] ev);
        return (cur & ~clr) | ev;
    endfunction

endpackage

// File: rtl/cirq_wm_detect.sv
module cirq_wm_detect #(
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] lo_mark,
    input  logic [OCC_W-1:0] hi_mark,
    output logic             hi_evt,
    output logic             lo_evt
);

    logic above, below;
    logic above_q, below_q;

    assign above = occ > hi_mark;
    assign below = occ < lo_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q <= 1'b0;
            below_q <= 1'b0;
        end else begin
            above_q <= above;
            below_q <= below;
        end
    end

    assign hi_evt = above & ~above_q;
    assign lo_evt = below & ~below_q;

    AST_HI_SINGLE: assert property (@(posedge clk) disable iff (rst) hi_evt |=> !hi_evt); // R3
    AST_LO_SINGLE: assert property (@(posedge clk) disable iff (rst) lo_evt |=> !lo_evt); // R4

endmodule

// File: rtl/cirq_chan.sv
module cirq_chan
    import cirq_pkg::*;
#(
    parameter int OCC_W      = 5,
    parameter int RING_DEPTH = 16,
    localparam int WD_W      = (2 * OCC_W > STAT_W) ? 2 * OCC_W : STAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           reg_sel,
    input  logic [WD_W-1:0]    wdata,
    input  logic               done_pulse,
    input  logic               err_pulse,
    input  logic [OCC_W-1:0]   src_occ,
    input  logic [OCC_W-1:0]   dst_occ,
    output logic [HEN_W-1:0]   host_en,
    output logic               misc_en,
    output logic [STAT_W-1:0]  status,
    output logic [2*OCC_W-1:0] src_wm,
    output logic [2*OCC_W-1:0] dst_wm,
    output logic               pending
);

    localparam logic [OCC_W-1:0] HI_RESET = OCC_W'(RING_DEPTH);

    cause_t             ev;
    logic [STAT_W-1:0]  clr_mask;
    logic [STAT_W-1:0]  en_mask;
    logic               wr_stat;

    cirq_wm_detect #(.OCC_W(OCC_W)) u_src_wm (
        .clk     (clk),
        .rst     (rst),
        .occ     (src_occ),
        .lo_mark (src_wm[OCC_W-1:0]),
        .hi_mark (src_wm[2*OCC_W-1:OCC_W]),
        .hi_evt  (ev.src_hi),
        .lo_evt  (ev.src_lo)
    );

    cirq_wm_detect #(.OCC_W(OCC_W)) u_dst_wm (
        .clk     (clk),
        .rst     (rst),
        .occ     (dst_occ),
        .lo_mark (dst_wm[OCC_W-1:0]),
        .hi_mark (dst_wm[2*OCC_W-1:OCC_W]),
        .hi_evt  (ev.dst_hi),
        .lo_evt  (ev.dst_lo)
    );

    assign ev.done = done_pulse;
    assign ev.err  = err_pulse;

    assign wr_stat  = wr_en && (reg_sel == REG_STATUS);
    assign clr_mask = wr_stat ? wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= w1c_merge(status, clr_mask, ev);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_en <= '0;
            misc_en <= 1'b0;
            src_wm  <= {HI_RESET, {OCC_W{1'b0}}};
            dst_wm  <= {HI_RESET, {OCC_W{1'b0}}};
        end else if (wr_en) begin
            case (reg_sel)
                REG_HOST_EN: host_en <= wdata[HEN_W-1:0];
                REG_MISC_EN: misc_en <= wdata[0];
                REG_SRC_WM:  src_wm  <= wdata[2*OCC_W-1:0];
                REG_DST_WM:  dst_wm  <= wdata[2*OCC_W-1:0];
                default: ;
            endcase
        end
    end

    assign en_mask = {misc_en, host_en};
    assign pending = |(status & en_mask);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (status == '0 && host_en == '0 && !misc_en)); // R1
    AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst) done_pulse |=> status[B_DONE]); // R2
    AST_ERR_LATCH_MASKED: assert property (@(posedge clk) disable iff (rst) (err_pulse && !misc_en) |=> status[B_ERR]); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (wr_stat && wdata[B_ERR] && !err_pulse) |=> !status[B_ERR]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (wr_stat && wdata[B_DONE] && done_pulse) |=> status[B_DONE]); // R7
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst) (host_en == '0 && !misc_en) |-> !pending); // R8

endmodule

// File: rtl/cpy_irq_agg.sv
module cpy_irq_agg
    import cirq_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int RING_DEPTH = 16,
    parameter int DATA_W     = 32,
    localparam int OCC_W     = $clog2(RING_DEPTH + 1),
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W    = CH_W + 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_CH-1:0]          done_pulse,
    input  logic [NUM_CH-1:0]          err_pulse,
    input  logic [NUM_CH*OCC_W-1:0]    src_occ,
    input  logic [NUM_CH*OCC_W-1:0]    dst_occ,
    output logic [NUM_CH*STAT_W-1:0]   chan_status,
    output logic [NUM_CH-1:0]          ch_summary,
    output logic                       irq_out
);

    localparam int WD_W = (2 * OCC_W > STAT_W) ? 2 * OCC_W : STAT_W;

    logic [CH_W-1:0]    addr_ch;
    reg_sel_e           addr_sel;
    logic [NUM_CH-1:0]  wr_sel;

    logic [HEN_W-1:0]   host_en_a [NUM_CH];
    logic               misc_en_a [NUM_CH];
    logic [STAT_W-1:0]  status_a  [NUM_CH];
    logic [2*OCC_W-1:0] src_wm_a  [NUM_CH];
    logic [2*OCC_W-1:0] dst_wm_a  [NUM_CH];

    logic               irq_q;
    logic               unused_wdata_hi;

    assign addr_ch  = bus_addr[ADDR_W-1:3];
    assign addr_sel = sel_decode(bus_addr[2:0]);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WD_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [CH_W-1:0] CH_ID = CH_W'(c);

        assign wr_sel[c] = bus_we && (addr_ch == CH_ID);

        cirq_chan #(
            .OCC_W      (OCC_W),
            .RING_DEPTH (RING_DEPTH)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_sel[c]),
            .reg_sel    (addr_sel),
            .wdata      (bus_wdata[WD_W-1:0]),
            .done_pulse (done_pulse[c]),
            .err_pulse  (err_pulse[c]),
            .src_occ    (src_occ[c*OCC_W +: OCC_W]),
            .dst_occ    (dst_occ[c*OCC_W +: OCC_W]),
            .host_en    (host_en_a[c]),
            .misc_en    (misc_en_a[c]),
            .status     (status_a[c]),
            .src_wm     (src_wm_a[c]),
            .dst_wm     (dst_wm_a[c]),
            .pending    (ch_summary[c])
        );

        assign chan_status[c*STAT_W +: STAT_W] = status_a[c];
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_sel == REG_SUMMARY) begin
            bus_rdata[NUM_CH-1:0] = ch_summary;
        end else if (int'(addr_ch) < NUM_CH) begin
            case (addr_sel)
                REG_HOST_EN: bus_rdata[HEN_W-1:0]   = host_en_a[addr_ch];
                REG_MISC_EN: bus_rdata[0]           = misc_en_a[addr_ch];
                REG_STATUS:  bus_rdata[STAT_W-1:0]  = status_a[addr_ch];
                REG_SRC_WM:  bus_rdata[2*OCC_W-1:0] = src_wm_a[addr_ch];
                REG_DST_WM:  bus_rdata[2*OCC_W-1:0] = dst_wm_a[addr_ch];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |ch_summary;
        end
    end

    assign irq_out = irq_q;

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (irq_out == $past(|ch_summary))); // R9
    AST_IRQ_RESET: assert property (@(posedge clk) rst |=> !irq_out); // R1

endmodule

// File: tb/cpy_irq_agg_tb.sv
module cpy_irq_agg_tb;

    localparam int NCH   = 4;
    localparam int DEPTH = 16;
    localparam int OW    = 5;
    localparam int SW    = 6;
    localparam int AW    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    done_pulse = '0;
    logic [NCH-1:0]    err_pulse = '0;
    logic [NCH*OW-1:0] src_occ = '0;
    logic [NCH*OW-1:0] dst_occ = '0;
    logic [NCH*SW-1:0] chan_status;
    logic [NCH-1:0]    ch_summary;
    logic              irq_out;

    cpy_irq_agg #(.NUM_CH(NCH), .RING_DEPTH(DEPTH), .DATA_W(32)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse),
        .err_pulse(err_pulse), .src_occ(src_occ), .dst_occ(dst_occ),
        .chan_status(chan_status), .ch_summary(ch_summary), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Requirement-level model of the block.
    logic [SW-1:0] m_stat [NCH];
    logic [4:0]    m_hen  [NCH];
    logic          m_men  [NCH];
    logic [OW-1:0] m_slo [NCH], m_shi [NCH], m_dlo [NCH], m_dhi [NCH];
    logic          m_sab [NCH], m_sbe [NCH], m_dab [NCH], m_dbe [NCH];
    logic          m_irq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NCH-1:0] exp_summary();
        logic [NCH-1:0] s;
        for (int c = 0; c < NCH; c++) s[c] = |(m_stat[c] & {m_men[c], m_hen[c]});
        return s;
    endfunction

    function automatic logic [NCH*SW-1:0] exp_status();
        logic [NCH*SW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*SW +: SW] = m_stat[c];
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_stat[c] = '0; m_hen[c] = '0; m_men[c] = 1'b0;
            m_slo[c] = '0; m_dlo[c] = '0; m_shi[c] = OW'(DEPTH); m_dhi[c] = OW'(DEPTH);
            m_sab[c] = 1'b0; m_sbe[c] = 1'b0; m_dab[c] = 1'b0; m_dbe[c] = 1'b0;
        end
        m_irq = 1'b0;
    endtask

    // One clock: model the edge from the currently driven inputs, then compare.
    task automatic step();
        logic sum_old;
        sum_old = |exp_summary();
        for (int c = 0; c < NCH; c++) begin
            logic [OW-1:0] so, dso;
            logic [SW-1:0] ev, clr;
            logic wr;
            so  = src_occ[c*OW +: OW];
            dso = dst_occ[c*OW +: OW];
            ev = '0;
            ev[0] = done_pulse[c];
            ev[5] = err_pulse[c];
            ev[1] = (so > m_shi[c]) && !m_sab[c];
            ev[2] = (so < m_slo[c]) && !m_sbe[c];
            ev[3] = (dso > m_dhi[c]) && !m_dab[c];
            ev[4] = (dso < m_dlo[c]) && !m_dbe[c];
            m_sab[c] = so > m_shi[c];  m_sbe[c] = so < m_slo[c];
            m_dab[c] = dso > m_dhi[c]; m_dbe[c] = dso < m_dlo[c];
            wr = bus_we && (int'(bus_addr[AW-1:3]) == c);
            clr = (wr && bus_addr[2:0] == 3'd2) ? bus_wdata[SW-1:0] : '0;
            m_stat[c] = (m_stat[c] & ~clr) | ev;
            if (wr) begin
                case (bus_addr[2:0])
                    3'd0: m_hen[c] = bus_wdata[4:0];
                    3'd1: m_men[c] = bus_wdata[0];
                    3'd3: begin m_slo[c] = bus_wdata[OW-1:0]; m_shi[c] = bus_wdata[2*OW-1:OW]; end
                    3'd4: begin m_dlo[c] = bus_wdata[OW-1:0]; m_dhi[c] = bus_wdata[2*OW-1:OW]; end
                    default: ;
                endcase
            end
        end
        m_irq = sum_old;
        @(posedge clk);
        @(negedge clk);
        done_pulse = '0;
        err_pulse  = '0;
        bus_we     = 1'b0;
        chk("R2 R3 R4 R5 R6 R7 status", 32'(chan_status), 32'(exp_status()));
        chk("R8 summary", 32'(ch_summary), 32'(exp_summary()));
        chk("R9 irq", 32'(irq_out), 32'(m_irq));
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        bus_we = 1'b1;
        bus_addr = AW'((ch << 3) | sel);
        bus_wdata = d;
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] d);
        bus_we = 1'b0;
        bus_addr = AW'((ch << 3) | sel);
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input int ch, input int v);
        src_occ[ch*OW +: OW] = OW'(v);
    endtask

    task automatic set_dst(input int ch, input int v);
        dst_occ[ch*OW +: OW] = OW'(v);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = $urandom(32'h5EED);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values through the bus and the ports.
        chk("R1 status", 32'(chan_status), 32'd0);
        chk("R1 summary", 32'(ch_summary), 32'd0);
        chk("R1 irq", 32'(irq_out), 32'd0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, 0, d); chk("R1 host enable", d, 32'd0);
            rd(c, 1, d); chk("R1 misc enable", d, 32'd0);
            rd(c, 3, d); chk("R1 source marks", d, 32'(DEPTH << OW));
            rd(c, 4, d); chk("R1 dest marks", d, 32'(DEPTH << OW));
        end

        // R2 R5: copy-complete with all enables clear latches but stays quiet.
        done_pulse[0] = 1'b1;
        step();
        chk("R5 latched while disabled", 32'(chan_status[5:0]), 32'h01);
        chk("R5 no summary when disabled", 32'(ch_summary), 32'd0);
        step();
        chk("R5 irq stays low", 32'(irq_out), 32'd0);

        // R8 R9: enabling copy-complete raises summary, line follows a cycle later.
        wr(0, 0, 32'h01);
        step();
        chk("R8 summary bit 0", 32'(ch_summary), 32'h1);
        chk("R9 irq lags summary", 32'(irq_out), 32'd0);
        step();
        chk("R9 irq raised", 32'(irq_out), 32'd1);

        // R7: event and clear of the same bit in one cycle.
        done_pulse[0] = 1'b1;
        wr(0, 2, 32'h01);
        step();
        chk("R7 set wins over clear", 32'(chan_status[0]), 32'd1);

        // R6: clearing another bit does nothing; clearing bit 0 clears it.
        wr(0, 2, 32'h20);
        step();
        chk("R6 unrelated clear", 32'(chan_status[0]), 32'd1);
        wr(0, 2, 32'h01);
        step();
        chk("R6 w1c clears", 32'(chan_status[5:0]), 32'd0);
        step();
        chk("R9 irq drops", 32'(irq_out), 32'd0);

        // R3: source ring high mark crossing on channel 1, marks lo=2 hi=5.
        wr(1, 3, 32'((5 << OW) | 2));
        set_src(1, 3);
        step();
        set_src(1, 6);
        step();
        chk("R3 src high crossing", 32'(chan_status[SW+1]), 32'd1);
        wr(1, 2, 32'h02);
        step();
        step();
        chk("R3 no refire while above", 32'(chan_status[SW+1]), 32'd0);
        set_src(1, 4);
        step();
        set_src(1, 7);
        step();
        chk("R3 refire after new crossing", 32'(chan_status[SW+1]), 32'd1);

        // R4: fall below low mark on source ring and destination ring.
        set_src(1, 1);
        step();
        chk("R4 src low crossing", 32'(chan_status[SW+2]), 32'd1);
        wr(2, 4, 32'((9 << OW) | 4));
        set_dst(2, 6);
        step();
        set_dst(2, 2);
        step();
        chk("R4 dst low crossing", 32'(chan_status[2*SW+4]), 32'd1);
        set_dst(2, 12);
        step();
        chk("R3 dst high crossing", 32'(chan_status[2*SW+3]), 32'd1);

        // R8: error routed through the misc enable.
        wr(3, 1, 32'h1);
        step();
        err_pulse[3] = 1'b1;
        step();
        chk("R8 error enable", 32'(ch_summary[3]), 32'd1);

        // R10: summary readable from any channel; writes to it ignored; readback.
        wr(1, 5, 32'hFFFF_FFFF);
        step();
        rd(2, 5, d);
        chk("R10 summary read", d, 32'(exp_summary()));
        rd(2, 4, d);
        chk("R10 dest marks readback", d, 32'((9 << OW) | 4));
        rd(3, 1, d);
        chk("R10 misc readback", d, 32'd1);

        // Random phase: pulses, occupancy moves and register writes together.
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                done_pulse[c] = ($urandom_range(0, 3) == 0);
                err_pulse[c]  = ($urandom_range(0, 5) == 0);
                if ($urandom_range(0, 2) == 0) set_src(c, $urandom_range(0, DEPTH));
                if ($urandom_range(0, 2) == 0) set_dst(c, $urandom_range(0, DEPTH));
            end
            if ($urandom_range(0, 2) == 0) begin
                int ch, sel;
                logic [31:0] v;
                ch  = $urandom_range(0, NCH - 1);
                sel = $urandom_range(0, 7);
                if (sel == 3 || sel == 4)
                    v = 32'(($urandom_range(0, 15) << OW) | $urandom_range(0, 15));
                else
                    v = $urandom;
                wr(ch, sel, v);
            end
            step();
        end

        finish_run();
    end

endmodule